// File: doc/BRIEF.md
# Synchronous master serial receiver

This block receives words over a half-duplex synchronous serial link on which it is the clock master. It drives the serial clock from a programmable 8-bit divisor of the system clock. It samples the incoming data line at each falling edge of that clock, least-significant bit first. Word length is 8 bits, or 9 bits when the ninth-bit option is on. In that case the ninth bit is reported on its own status output next to the 8-bit data.

Reception runs only while synchronous master mode is enabled and one of two receive enables is active. The one-shot enable is set by a pulse and takes exactly one word, then clears itself. The continuous enable is a level and takes words back to back for as long as it stays high. When both are active, the continuous enable wins. A completed word is offered on a valid/ready output. `rx_valid` rises when a word lands and stays high, with data stable, until `rx_ready` is sampled high together with it. `rx_ready` while `rx_valid` is low has no effect. The serial link cannot be stalled, so back-pressure cannot hold off the sender. A word that completes while the previous one is still unaccepted is dropped and raises the overrun flag. That flag lives only while the continuous enable is high.

Top module: `srx_sync_master_rx`

## Requirements
- R1: While `sync_master` is 0, `sclk` stays 0, `single_set` is ignored (`single_busy` stays 0) and no word is received, even with `cont_en` high.
- R2: While active, `sclk` toggles every `baud_div`+1 system clocks, so its period is 2*(`baud_div`+1) cycles. It idles at 0 when neither enable is active.
- R3: `sdata` is sampled when `sclk` falls. The first sampled bit is bit 0 of the word, and `rx_data[7:0]` presents bits 0..7.
- R4: A `single_set` pulse sets `single_busy`. With `cont_en` low, exactly one word (8 or 9 `sclk` rising edges) is received, `single_busy` returns to 0 in the cycle `rx_valid` rises, and `sclk` then stays low.
- R5: With `nine_bit` = 1, the ninth sampled bit appears on `rx_bit8`. With `nine_bit` = 0, `rx_bit8` reads 0 and a word is 8 bits.
- R6: With `cont_en` high, words are received back to back. Clearing `cont_en` aborts any partial word, stops `sclk`, and no further word arrives.
- R7: When `cont_en` and `single_busy` are both set, reception is continuous and `single_busy` is not consumed. After `cont_en` clears, the one-shot enable restarts from bit 0, takes one word, then clears.
- R8: `rx_valid` holds until accepted by `rx_ready` and then drops. `irq` equals `rx_valid` gated by `irq_en`.
- R9: A word completing while `rx_valid` is high and `rx_ready` is low sets `overrun` and is discarded; `rx_data` keeps the older word.
- R10: `overrun` stays set while `cont_en` is high and is 0 one cycle after `cont_en` is low.
- R11: After reset, `sclk`, `rx_valid`, `overrun`, `single_busy` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_master | input | 1 | Enables synchronous master operation |
| single_set | input | 1 | One-cycle pulse that arms a one-word receive |
| cont_en | input | 1 | Continuous receive enable; clearing it clears overrun |
| nine_bit | input | 1 | Selects 9-bit words |
| baud_div | input | 8 | Half-period of `sclk` minus one, in system clocks |
| irq_en | input | 1 | Interrupt enable |
| sdata | input | 1 | Serial data from the link |
| sclk | output | 1 | Serial clock driven to the link |
| single_busy | output | 1 | One-shot enable state |
| rx_valid | output | 1 | A received word is waiting |
| rx_ready | input | 1 | Consumer accepts the waiting word |
| rx_data | output | 8 | Received bits 0..7 |
| rx_bit8 | output | 1 | Received ninth bit |
| overrun | output | 1 | A word was lost because the previous one was unaccepted |
| irq | output | 1 | Receive interrupt |

## Verification
In 8-bit mode with the fastest clock, every byte value is received one word at a time. This separates bit-order and bit-slot errors, because each data bit is exercised in both states. In 9-bit mode every byte is also swept, with the ninth bit set to the byte's parity. That tells a dropped or misplaced ninth bit apart from a shifted data field, and a few slow divisors, up to the largest, confirm the clock period. Continuous runs with prompt acceptance show back-to-back framing. Runs with late acceptance tell an overwrite from a correctly dropped word. A run with both enables shows which enable governs and that the one-shot enable survives continuous mode.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_CONT   = 2'd2
  } srx_mode_e;

  function automatic int srx_word_bits(input logic nine, input int data_w);
    return nine ? data_w + 1 : data_w;
  endfunction

endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt;
  logic             expire;

  assign expire   = (cnt == '0);
  // sclk is high and about to drop at this edge: the sampling point
  assign fall_evt = run & ~restart & expire & sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run || restart) begin
      cnt  <= div;
      sclk <= 1'b0;
    end else if (expire) begin
      cnt  <= div;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            fall_evt,
  input  logic            sdata,
  input  logic            nine,
  output logic            word_done,
  output logic [DATA_W:0] word
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W);

  logic [CNT_W-1:0] bitcnt;
  logic [CNT_W-1:0] last_idx;
  logic [DATA_W:0]  shreg;

  assign last_idx  = nine ? LAST_LONG : LAST_SHORT;
  assign word_done = fall_evt & (bitcnt == last_idx);

  // current sample written straight into its bit slot
  always_comb begin
    word = shreg;
    for (int i = 0; i <= DATA_W; i++) begin
      if (bitcnt == CNT_W'(i)) word[i] = sdata;
    end
    if (!nine) word[DATA_W] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      shreg  <= '0;
    end else if (clear) begin
      bitcnt <= '0;
    end else if (fall_evt) begin
      shreg  <= word;
      bitcnt <= word_done ? '0 : bitcnt + 1'b1;
    end
  end

endmodule

// File: rtl/srx_holdreg.sv
module srx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W:0]   word_in,
  input  logic              ready,
  input  logic              cont_en,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              bit8,
  output logic              overrun
);

  logic lost;

  assign lost = load & valid & ~ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      bit8  <= 1'b0;
    end else if (load && !lost) begin
      valid <= 1'b1;
      data  <= word_in[DATA_W-1:0];
      bit8  <= word_in[DATA_W];
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun <= 1'b0;
    else        overrun <= cont_en & (overrun | lost);
  end

endmodule

// File: rtl/srx_sync_master_rx.sv
module srx_sync_master_rx
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_master,
  input  logic              single_set,
  input  logic              cont_en,
  input  logic              nine_bit,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              irq_en,
  input  logic              sdata,
  output logic              sclk,
  output logic              single_busy,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              overrun,
  output logic              irq
);

  srx_mode_e       mode;
  logic            single_q;
  logic            cont_q;
  logic            run;
  logic            restart;
  logic            fall_evt;
  logic            word_done;
  logic [DATA_W:0] word;

  always_comb begin
    if (!sync_master)  mode = MODE_IDLE;
    else if (cont_en)  mode = MODE_CONT;
    else if (single_q) mode = MODE_SINGLE;
    else               mode = MODE_IDLE;
  end

  assign run     = (mode != MODE_IDLE);
  assign restart = cont_q & ~cont_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      cont_q   <= 1'b0;
    end else begin
      cont_q <= cont_en;
      if (!sync_master)                         single_q <= 1'b0;
      else if (single_set)                      single_q <= 1'b1;
      else if (word_done && mode == MODE_SINGLE) single_q <= 1'b0;
    end
  end

  srx_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .restart  (restart),
    .div      (baud_div),
    .sclk     (sclk),
    .fall_evt (fall_evt)
  );

  srx_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (~run | restart),
    .fall_evt  (fall_evt),
    .sdata     (sdata),
    .nine      (nine_bit),
    .word_done (word_done),
    .word      (word)
  );

  srx_holdreg #(.DATA_W(DATA_W)) i_holdreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (word_done),
    .word_in (word),
    .ready   (rx_ready),
    .cont_en (cont_en),
    .valid   (rx_valid),
    .data    (rx_data),
    .bit8    (rx_bit8),
    .overrun (overrun)
  );

  assign single_busy = single_q;
  assign irq         = rx_valid & irq_en;

endmodule

// File: rtl/srx_rx_checker.sv
module srx_rx_checker (
  input logic clk,
  input logic rst_n,
  input logic sync_master,
  input logic single_set,
  input logic cont_en,
  input logic sclk,
  input logic single_busy,
  input logic rx_valid,
  input logic rx_ready,
  input logic overrun,
  input logic word_done
);

  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_master |=> (!sclk && !single_busy));

  a_r2_sclk_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_en && !single_busy) |=> !sclk);

  a_r4_single_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_master && !cont_en && !single_set && word_done) |=> !single_busy);

  a_r7_single_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_master && cont_en && single_busy) |=> single_busy);

  a_r6_valid_from_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(word_done));

  a_r8_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_valid && word_done));

  a_r10_overrun_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_en |=> !overrun);

endmodule

bind srx_sync_master_rx srx_rx_checker i_rx_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_master (sync_master),
  .single_set  (single_set),
  .cont_en     (cont_en),
  .sclk        (sclk),
  .single_busy (single_busy),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .overrun     (overrun),
  .word_done   (word_done)
);

// File: tb/test_srx_sync_master_rx.sv
module test_srx_sync_master_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_master = 1'b0;
  logic       single_set = 1'b0;
  logic       cont_en = 1'b0;
  logic       nine_bit = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic       irq_en = 1'b0;
  logic       sdata = 1'b0;
  logic       sclk;
  logic       single_busy;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8;
  logic       overrun;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  logic [8:0] tx_words [8];
  int tx_idx = 0;
  int tx_k = 0;
  int tx_len = 8;
  int rise_cnt = 0;
  longint last_rise = 0;
  longint period = 0;

  always #10 clk = ~clk;

  srx_sync_master_rx i_srx_sync_master_rx (
    .clk(clk), .rst_n(rst_n), .sync_master(sync_master), .single_set(single_set),
    .cont_en(cont_en), .nine_bit(nine_bit), .baud_div(baud_div), .irq_en(irq_en),
    .sdata(sdata), .sclk(sclk), .single_busy(single_busy), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_bit8(rx_bit8), .overrun(overrun),
    .irq(irq)
  );

  // link model: present the next bit on each rising sclk
  always @(posedge sclk) begin
    sdata = tx_words[tx_k][tx_idx];
    rise_cnt++;
    period = ($time - last_rise) / 20;
    last_rise = $time;
  end

  always @(negedge sclk) begin
    tx_idx++;
    if (tx_idx >= tx_len) begin
      tx_idx = 0;
      tx_k = (tx_k + 1) % 8;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tx_reset(input bit nine);
    tx_idx = 0;
    tx_k = 0;
    tx_len = nine ? 9 : 8;
  endtask

  task automatic wait_valid();
    for (int t = 0; t < 6000 && !rx_valid; t++) @(negedge clk);
  endtask

  task automatic accept();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic single_word(input int div, input bit nine, input logic [8:0] w);
    int r0;
    int r1;
    @(negedge clk);
    baud_div = 8'(div);
    nine_bit = nine;
    tx_words[0] = w;
    tx_reset(nine);
    r0 = rise_cnt;
    single_set = 1'b1;
    @(negedge clk);
    single_set = 1'b0;
    check(single_busy == 1'b1, "R4 armed", single_busy, 1);
    wait_valid();
    check(rx_data == w[7:0], "R3 data", rx_data, w[7:0]);
    check(rx_bit8 == (nine & w[8]), "R5 ninth bit", rx_bit8, nine & w[8]);
    check(single_busy == 1'b0, "R4 self clear", single_busy, 0);
    check(rise_cnt - r0 == (nine ? 9 : 8), "R4 edge count", rise_cnt - r0, nine ? 9 : 8);
    check(period == 2 * (div + 1), "R2 period", period, 2 * (div + 1));
    check(irq == irq_en, "R8 irq", irq, irq_en);
    r1 = rise_cnt;
    repeat (3 * (div + 1) + 2) @(negedge clk);
    check(rise_cnt == r1 && sclk == 1'b0, "R4 clock stopped", rise_cnt - r1, 0);
    check(rx_valid == 1'b1, "R8 held", rx_valid, 1);
    accept();
    check(rx_valid == 1'b0, "R8 accepted", rx_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) tx_words[i] = 9'((i * 83 + 29) ^ (i << 6));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check({sclk, rx_valid, overrun, single_busy, irq} == 5'b0, "R11 reset",
          {sclk, rx_valid, overrun, single_busy, irq}, 0);

    // R1: mode off, enables ignored
    begin
      int r0;
      r0 = rise_cnt;
      cont_en = 1'b1;
      single_set = 1'b1;
      @(negedge clk);
      single_set = 1'b0;
      repeat (50) @(negedge clk);
      check(rise_cnt == r0 && !sclk, "R1 no clock", rise_cnt - r0, 0);
      check(!single_busy, "R1 single ignored", single_busy, 0);
      check(!rx_valid, "R1 no word", rx_valid, 0);
      cont_en = 1'b0;
      @(negedge clk);
    end
    sync_master = 1'b1;

    // R3 R5: every byte, 8-bit, fastest clock
    irq_en = 1'b1;
    for (int v = 0; v < 256; v++) single_word(0, 1'b0, {1'b1, 8'(v)});
    // R5: every byte, 9-bit, ninth bit = parity
    irq_en = 1'b0;
    for (int v = 0; v < 256; v++) single_word(1, 1'b1, {^8'(v), 8'(v)});
    // R2: slower divisors
    single_word(3, 1'b1, 9'h1A5);
    single_word(7, 1'b0, 9'h05A);
    single_word(255, 1'b1, 9'h0C3);

    // R6: continuous, prompt acceptance
    begin
      int r0;
      @(negedge clk);
      baud_div = 8'd2;
      nine_bit = 1'b1;
      tx_reset(1'b1);
      cont_en = 1'b1;
      for (int k = 0; k < 6; k++) begin
        wait_valid();
        check({rx_bit8, rx_data} == tx_words[k], "R6 stream word", {rx_bit8, rx_data}, tx_words[k]);
        accept();
      end
      cont_en = 1'b0;
      repeat (2) @(negedge clk);
      r0 = rise_cnt;
      repeat (100) @(negedge clk);
      check(rise_cnt == r0 && !sclk, "R6 stopped", rise_cnt - r0, 0);
      check(!rx_valid, "R6 no more words", rx_valid, 0);
    end

    // R9 R10: overrun by late acceptance
    begin
      @(negedge clk);
      baud_div = 8'd0;
      nine_bit = 1'b0;
      tx_reset(1'b0);
      cont_en = 1'b1;
      wait_valid();
      repeat (20) @(negedge clk);
      check(overrun == 1'b1, "R9 overrun set", overrun, 1);
      check(rx_data == tx_words[0][7:0], "R9 old word kept", rx_data, tx_words[0][7:0]);
      accept();
      check(!rx_valid, "R8 accept after overrun", rx_valid, 0);
      check(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
      cont_en = 1'b0;
      repeat (2) @(negedge clk);
      check(overrun == 1'b0, "R10 overrun cleared", overrun, 0);
      if (rx_valid) accept();
    end

    // R7: both enables, continuous wins, then one-shot follows
    begin
      @(negedge clk);
      baud_div = 8'd3;
      nine_bit = 1'b0;
      tx_reset(1'b0);
      single_set = 1'b1;
      cont_en = 1'b1;
      @(negedge clk);
      single_set = 1'b0;
      for (int k = 0; k < 3; k++) begin
        wait_valid();
        check(rx_data == tx_words[k][7:0], "R7 continuous word", rx_data, tx_words[k][7:0]);
        check(single_busy == 1'b1, "R7 one-shot kept", single_busy, 1);
        accept();
      end
      cont_en = 1'b0;
      repeat (2) @(negedge clk);
      tx_idx = 0;
      tx_k = 5;
      wait_valid();
      check(rx_data == tx_words[5][7:0], "R7 one-shot word", rx_data, tx_words[5][7:0]);
      check(single_busy == 1'b0, "R7 one-shot consumed", single_busy, 0);
      accept();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule